// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block sits between a processor datapath and a memory that is one 32-bit word wide. For every request it forms the effective byte address from a base value plus a sign-extended 16-bit displacement. It then issues a word-granular address, a four-bit lane enable mask and, for stores, write data steered onto the right byte lane. Accesses are either a full word or a single byte.

For loads, the block remembers the lane and extension mode of the last accepted request. When the memory word comes back, the block extracts the addressed byte and widens it with sign or zero fill, or passes the whole word through. A module parameter picks the byte ordering, which decides which lane a given byte offset lands on. A word request whose effective address is not a multiple of four never reaches memory and raises an error pulse instead.

All outputs are registered. Request outputs appear one clock after the request, and load data appears one clock after the returned word.

Top module: `lsu_lane_aligner`

## Requirements
- R1: The effective address is `base_i` plus `offset_i` sign-extended to 32 bits, and `mem_addr_o` is that address with bits 1:0 cleared, presented with `mem_req_o` high on the cycle after an accepted request.
- R2: An aligned word access (`req_byte_i`=0, effective address bits 1:0 = 0) drives `mem_be_o` = 4'b1111, and a word store passes `st_data_i` unchanged to `mem_wdata_o`.
- R3: A word access whose effective address bits 1:0 are nonzero is misaligned. On the next cycle `misalign_err_o` is 1, `mem_req_o` is 0 and `mem_be_o` is 0. The error is 0 again on the following cycle when no new misaligned request arrives.
- R4: A byte store asserts exactly one bit of `mem_be_o` (bit i enables data bits 8i+7:8i) and copies `st_data_i[7:0]` onto all four lanes of `mem_wdata_o`.
- R5: With `BIG_ENDIAN`=0, byte offset k (effective address bits 1:0) maps to lane k. With `BIG_ENDIAN`=1, it maps to lane 3-k, so offset 0 is the most significant byte. The same mapping selects the byte extracted on loads.
- R6: A byte load with `req_signed_i`=1 returns the selected byte in bits 7:0 with bits 31:8 all equal to its bit 7 (0x94 gives 0xFFFFFF94).
- R7: A byte load with `req_signed_i`=0 returns the selected byte with bits 31:8 zero (0x94 gives 0x00000094).
- R8: A word load returns `rd_word_i` unchanged on `ld_data_o`, with `ld_valid_o` high on the cycle after `rd_valid_i`.
- R9: After reset, `mem_req_o`, `mem_we_o`, `mem_be_o`, `misalign_err_o`, `ld_valid_o` and `ld_data_o` are all zero. Idle cycles drive `mem_be_o` to zero.
- R10: A byte access is never flagged as misaligned, whatever its address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_byte_i | input | 1 | 1 = byte access, 0 = word access |
| req_signed_i | input | 1 | Sign-extend a loaded byte |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| st_data_i | input | 32 | Store data |
| rd_valid_i | input | 1 | Memory read word is valid |
| rd_word_i | input | 32 | Word returned from memory |
| mem_req_o | output | 1 | Memory access issued |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_be_o | output | 4 | Lane enables, bit i = bits 8i+7:8i |
| mem_wdata_o | output | 32 | Lane-steered write data |
| misalign_err_o | output | 1 | Misaligned word access pulse |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Extracted and extended load result |

## Verification
The assertions check on every cycle that issued addresses are word-aligned, that an aligned word request yields a full mask, that a misaligned word request produces an error with no memory activity, that a byte request yields a single enable and no error, and that byte loads are filled with zeros or copies of bit 7. Other behaviour depends on the byte ordering and on values computed from the request, so only the bench scenarios can show it. This covers which lane a given offset selects in each ordering, the exact effective address sum with negative displacements, replication of store bytes, word pass-through and the error dropping after one cycle. The bench runs a little-endian and a big-endian instance side by side on the same stimulus.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 16;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    typedef struct packed {
        logic              mem_req;
        logic              mem_we;
        logic [ADDR_W-1:0] mem_addr;
        logic [LANES-1:0]  mem_be;
        logic [DATA_W-1:0] mem_wdata;
        logic              err;
        logic [LANE_W-1:0] pend_lane;
        logic              pend_byte;
        logic              pend_signed;
        logic              ld_valid;
        logic [DATA_W-1:0] ld_data;
    } align_state_t;
endpackage

// File: rtl/lsu_ea_calc.sv
module lsu_ea_calc
    import lsu_align_pkg::*;
(
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFF_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] ea_o
);
    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{(ADDR_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
        ea_o     = base_i + disp_ext;
    end
endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
    import lsu_align_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic [LANE_W-1:0] byte_off_i,
    output logic [LANE_W-1:0] lane_o,
    output logic [LANES-1:0]  mask_o
);
    generate
        if (BIG_ENDIAN) begin : g_big
            always_comb lane_o = LANE_W'(LANES - 1) - byte_off_i;
        end else begin : g_little
            always_comb lane_o = byte_off_i;
        end
    endgenerate

    always_comb mask_o = LANES'(1) << lane_o;
endmodule

// File: rtl/lsu_byte_extract.sv
module lsu_byte_extract
    import lsu_align_pkg::*;
(
    input  logic [DATA_W-1:0] word_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic              is_byte_i,
    input  logic              sign_i,
    output logic [DATA_W-1:0] data_o
);
    logic [7:0] sel_byte;
    logic       fill;

    always_comb begin
        sel_byte = word_i[8*lane_i +: 8];
        fill     = sign_i & sel_byte[7];
        if (is_byte_i) data_o = {{(DATA_W-8){fill}}, sel_byte};
        else           data_o = word_i;
    end
endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
    import lsu_align_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid_i,
    input  logic                     req_store_i,
    input  logic                     req_byte_i,
    input  logic                     req_signed_i,
    input  logic [ADDR_W-1:0]        base_i,
    input  logic [OFF_W-1:0]         offset_i,
    input  logic [DATA_W-1:0]        st_data_i,
    input  logic                     rd_valid_i,
    input  logic [DATA_W-1:0]        rd_word_i,
    output logic                     mem_req_o,
    output logic                     mem_we_o,
    output logic [ADDR_W-1:0]        mem_addr_o,
    output logic [LANES-1:0]         mem_be_o,
    output logic [DATA_W-1:0]        mem_wdata_o,
    output logic                     misalign_err_o,
    output logic                     ld_valid_o,
    output logic [DATA_W-1:0]        ld_data_o
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(LANES - 1);

    align_state_t      st_d, st_q;
    logic [ADDR_W-1:0] ea_w;
    logic [LANE_W-1:0] lane_w;
    logic [LANES-1:0]  lane_mask_w;
    logic [DATA_W-1:0] ext_w;
    logic              mis_w;

    lsu_ea_calc u_ea (
        .base_i   (base_i),
        .offset_i (offset_i),
        .ea_o     (ea_w)
    );

    lsu_lane_map #(.BIG_ENDIAN(BIG_ENDIAN)) u_map (
        .byte_off_i (ea_w[LANE_W-1:0]),
        .lane_o     (lane_w),
        .mask_o     (lane_mask_w)
    );

    lsu_byte_extract u_ext (
        .word_i    (rd_word_i),
        .lane_i    (st_q.pend_lane),
        .is_byte_i (st_q.pend_byte),
        .sign_i    (st_q.pend_signed),
        .data_o    (ext_w)
    );

    always_comb begin
        mis_w = ~req_byte_i & (ea_w[LANE_W-1:0] != '0);

        st_d          = st_q;
        st_d.mem_req  = 1'b0;
        st_d.mem_we   = 1'b0;
        st_d.mem_be   = '0;
        st_d.err      = 1'b0;
        st_d.ld_valid = 1'b0;

        if (req_valid_i) begin
            if (mis_w) begin
                st_d.err = 1'b1;
            end else begin
                st_d.mem_req     = 1'b1;
                st_d.mem_we      = req_store_i;
                st_d.mem_addr    = ea_w & ALIGN_MASK;
                st_d.mem_be      = req_byte_i ? lane_mask_w : '1;
                st_d.mem_wdata   = !req_store_i ? '0 :
                                   req_byte_i   ? {LANES{st_data_i[7:0]}} : st_data_i;
                st_d.pend_lane   = lane_w;
                st_d.pend_byte   = req_byte_i;
                st_d.pend_signed = req_signed_i;
            end
        end

        if (rd_valid_i) begin
            st_d.ld_valid = 1'b1;
            st_d.ld_data  = ext_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_req_o      = st_q.mem_req;
    assign mem_we_o       = st_q.mem_we;
    assign mem_addr_o     = st_q.mem_addr;
    assign mem_be_o       = st_q.mem_be;
    assign mem_wdata_o    = st_q.mem_wdata;
    assign misalign_err_o = st_q.err;
    assign ld_valid_o     = st_q.ld_valid;
    assign ld_data_o      = st_q.ld_data;

    AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[LANE_W-1:0] == '0)); // R1
    AST_ADDR_FROM_EA: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !mis_w) |=> (mem_addr_o == ($past(ea_w) & ALIGN_MASK))); // R1
    AST_WORD_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_byte_i && ea_w[LANE_W-1:0] == '0) |=> (mem_be_o == '1)); // R2
    AST_MISALIGN_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_byte_i && ea_w[LANE_W-1:0] != '0) |=> misalign_err_o); // R3
    AST_MISALIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err_o |-> (!mem_req_o && mem_be_o == '0)); // R3
    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_byte_i) |=> ($countones(mem_be_o) == 1)); // R4
    AST_BYTE_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_byte_i) |=> !misalign_err_o); // R10
    AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_i && st_q.pend_byte && st_q.pend_signed)
        |=> (ld_data_o[DATA_W-1:8] == {(DATA_W-8){ld_data_o[7]}})); // R6
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_i && st_q.pend_byte && !st_q.pend_signed)
        |=> (ld_data_o[DATA_W-1:8] == '0)); // R7
    AST_IDLE_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req_o |-> (mem_be_o == '0)); // R9
endmodule

// File: tb/lsu_lane_aligner_tb.sv
module lsu_lane_aligner_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0, req_byte = 1'b0, req_signed = 1'b0;
    logic [31:0] base = '0, st_data = '0, rd_word = '0;
    logic [15:0] offset = '0;
    logic        rd_valid = 1'b0;

    logic        l_req, l_we, l_err, l_lv, b_req, b_we, b_err, b_lv;
    logic [31:0] l_addr, l_wd, l_ld, b_addr, b_wd, b_ld;
    logic [3:0]  l_be, b_be;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lsu_lane_aligner #(.BIG_ENDIAN(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_store_i(req_store),
        .req_byte_i(req_byte), .req_signed_i(req_signed), .base_i(base),
        .offset_i(offset), .st_data_i(st_data), .rd_valid_i(rd_valid), .rd_word_i(rd_word),
        .mem_req_o(l_req), .mem_we_o(l_we), .mem_addr_o(l_addr), .mem_be_o(l_be),
        .mem_wdata_o(l_wd), .misalign_err_o(l_err), .ld_valid_o(l_lv), .ld_data_o(l_ld));

    lsu_lane_aligner #(.BIG_ENDIAN(1'b1)) dut_be_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_store_i(req_store),
        .req_byte_i(req_byte), .req_signed_i(req_signed), .base_i(base),
        .offset_i(offset), .st_data_i(st_data), .rd_valid_i(rd_valid), .rd_word_i(rd_word),
        .mem_req_o(b_req), .mem_we_o(b_we), .mem_addr_o(b_addr), .mem_be_o(b_be),
        .mem_wdata_o(b_wd), .misalign_err_o(b_err), .ld_valid_o(b_lv), .ld_data_o(b_ld));

    function automatic logic [31:0] f_ea(input logic [31:0] b, input logic [15:0] o);
        return b + {{16{o[15]}}, o};
    endfunction

    function automatic int f_lane(input logic [1:0] off, input bit big);
        return big ? 3 - int'(off) : int'(off);
    endfunction

    function automatic logic [31:0] f_load(input logic [31:0] w, input int lane,
                                           input bit byt, input bit sgn);
        logic [7:0] b8;
        b8 = w[8*lane +: 8];
        if (!byt) return w;
        return sgn ? {{24{b8[7]}}, b8} : {24'h0, b8};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_side(input bit big, input bit st, input bit byt,
                              input logic [31:0] ea, input logic [31:0] sd,
                              input logic req, input logic we, input logic [31:0] addr,
                              input logic [3:0] be, input logic [31:0] wd, input logic err);
        bit mis;
        logic [3:0] exp_be;
        mis = !byt && (ea[1:0] != 2'b00);
        exp_be = mis ? 4'b0000 : (byt ? 4'b0001 << f_lane(ea[1:0], big) : 4'b1111);
        if (mis) begin
            chk(err == 1'b1 && req == 1'b0, "R3 err/req on misaligned", {30'h0, err, req}, 32'h2);
            chk(be == 4'b0000, "R3 lanes off on misaligned", {28'h0, be}, 32'h0);
        end else begin
            chk(req == 1'b1 && we == st, "R1 req/we", {30'h0, req, we}, {30'h0, 1'b1, st});
            chk(addr == {ea[31:2], 2'b00}, "R1 word address", addr, {ea[31:2], 2'b00});
            chk(err == 1'b0, byt ? "R10 no error on byte" : "R2 no error aligned", {31'h0, err}, 32'h0);
            chk(be == exp_be, byt ? "R5 R4 byte lane" : "R2 full mask", {28'h0, be}, {28'h0, exp_be});
            if (st) begin
                if (byt) chk(wd == {4{sd[7:0]}}, "R4 replicated byte", wd, {4{sd[7:0]}});
                else     chk(wd == sd, "R2 word data", wd, sd);
            end
        end
    endtask

    task automatic txn(input bit st, input bit byt, input bit sgn, input logic [31:0] b,
                       input logic [15:0] o, input logic [31:0] sd, input logic [31:0] rw);
        logic [31:0] ea;
        bit mis;
        ea = f_ea(b, o);
        mis = !byt && (ea[1:0] != 2'b00);
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_byte = byt; req_signed = sgn;
        base = b; offset = o; st_data = sd;
        @(negedge clk);
        check_side(1'b0, st, byt, ea, sd, l_req, l_we, l_addr, l_be, l_wd, l_err);
        check_side(1'b1, st, byt, ea, sd, b_req, b_we, b_addr, b_be, b_wd, b_err);
        req_valid = 1'b0;
        rd_valid = !st && !mis;
        rd_word = rw;
        @(negedge clk);
        chk(l_err == 1'b0 && b_err == 1'b0, "R3 error lasts one cycle", {30'h0, l_err, b_err}, 32'h0);
        chk(l_be == 4'b0 && b_be == 4'b0, "R9 idle lanes off", {24'h0, l_be, b_be}, 32'h0);
        if (!st && !mis) begin
            chk(l_lv && b_lv, "R8 load valid", {30'h0, l_lv, b_lv}, 32'h3);
            chk(l_ld == f_load(rw, f_lane(ea[1:0], 1'b0), byt, sgn),
                !byt ? "R8 word load LE" : (sgn ? "R6 signed load LE" : "R7 unsigned load LE"),
                l_ld, f_load(rw, f_lane(ea[1:0], 1'b0), byt, sgn));
            chk(b_ld == f_load(rw, f_lane(ea[1:0], 1'b1), byt, sgn),
                !byt ? "R8 word load BE" : (sgn ? "R6 signed load BE" : "R7 unsigned load BE"),
                b_ld, f_load(rw, f_lane(ea[1:0], 1'b1), byt, sgn));
        end
        rd_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] rb, rs, rw;
        logic [15:0] ro;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!l_req && !l_we && l_be == 0 && !l_err && !l_lv && l_ld == 0,
            "R9 reset state LE", {26'h0, l_req, l_we, l_be}, 32'h0);
        chk(!b_req && !b_we && b_be == 0 && !b_err && !b_lv && b_ld == 0,
            "R9 reset state BE", {26'h0, b_req, b_we, b_be}, 32'h0);
        rst_n = 1'b1;
        // directed corners
        txn(1'b0, 1'b1, 1'b1, 32'h1000, 16'h0000, 32'h0, 32'h94949494); // R6 0x94 -> FFFFFF94
        txn(1'b0, 1'b1, 1'b0, 32'h1000, 16'h0000, 32'h0, 32'h94949494); // R7 0x94 -> 00000094
        txn(1'b1, 1'b0, 1'b0, 32'h2000, 16'hFFFC, 32'hCAFEF00D, 32'h0);  // R1 negative disp
        txn(1'b1, 1'b0, 1'b0, 32'h2001, 16'h0000, 32'h12345678, 32'h0);  // R3 misaligned
        txn(1'b0, 1'b0, 1'b0, 32'h2000, 16'h0002, 32'h0, 32'h0);         // R3 misaligned load
        for (int k = 0; k < 4; k++) begin
            txn(1'b1, 1'b1, 1'b0, 32'h3000, 16'(k), 32'hAABBCCDD, 32'h0);      // R4 R5
            txn(1'b0, 1'b1, 1'b0, 32'h3000, 16'(k), 32'h0, 32'h11223344);      // R5
            txn(1'b1, 1'b1, 1'b0, 32'h3000, 16'(k + 4), 32'h5A, 32'h0);        // R10
        end
        txn(1'b0, 1'b0, 1'b1, 32'h4000, 16'h0004, 32'h0, 32'hDEADBEEF);  // R8
        for (int i = 0; i < 300; i++) begin
            rb = $urandom; ro = 16'($urandom); rs = $urandom; rw = $urandom;
            if ($urandom % 2 != 0) rb[1:0] = 2'b00 - ro[1:0];
            txn(1'($urandom), 1'($urandom), 1'($urandom), rb, ro, rs, rw);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule